// File: doc/BRIEF.md
# Mode-Controlled Peripheral Bus Cycle Generator

This block sits behind a CPU register port and turns single CPU accesses into activity on a narrow peripheral bus. The CPU sees two locations: a 16-bit data window and a shared control location. Writing the control location loads a 9-bit mode register. Reading it returns a status word. The mode register decides what a data-window access does. It can run one byte-wide read or write cycle on the external 8-bit bus, strobed by either a hard-disk select or a floppy select. It can instead read or write an internal sector count register. It can also do nothing at all.

An external bus cycle runs in three parts: setup, select pulse and hold. The length of each part is a parameter counted in clock cycles. The CPU handshake holds off its ready until the whole cycle has finished. The status word reports three things: a sticky error flag raised by the DMA engine, whether the sector count has reached zero, and the live level of the data-request input. Software clears the error by writing the mode register with the direction bit flipped. The DMA engine counts sectors down through a decrement strobe. The block passes the data request on to the DMA engine unless the mode register blocks it.

Top module: `pbus_cycle_gen`

## Requirements
- R1: A data-window access when mode bit 4 is 0 and mode bit 7 is 1 runs exactly one byte cycle on the external bus. On a write, the bus carries the low byte of the CPU data and `bus_rw` is 0. On a read, `cpu_rdata` returns the sampled byte in bits 7:0 with bits 15:8 at 0.
- R2: Mode bit 3 picks the strobe. When it is 1, `hd_sel` pulses. When it is 0, `fd_sel` pulses. The two selects are never high together.
- R3: During a bus cycle, `bus_a1` equals mode bit 1. `bus_a2` equals mode bit 2 in floppy cycles and is 0 in hard-disk cycles.
- R4: When mode bit 7 is 0, a data-window access with bit 4 at 0 raises no select. `cpu_ready` then comes one cycle after acceptance, and a read returns 0.
- R5: When mode bit 4 is 1, a data-window write loads the sector count and a read returns it zero-extended, with no select raised. A `sec_dec` pulse lowers a nonzero count by one. At zero the count stays at zero.
- R6: The status word carries the error flag in bit 0, a count-equals-zero flag in bit 1 and the live `drq_in` level in bit 2. All other bits are 0. A `dma_err` pulse sets the error flag and it stays set. A mode write whose bit 8 differs from the current bit 8 clears it, in either direction. A mode write that keeps bit 8 leaves it set.
- R7: In a write cycle, `bus_doe`, `bus_rw`=0, the address lines and the data are driven for SETUP_CYC cycles before the select, stay unchanged through PULSE_CYC select cycles, and stay for HOLD_CYC cycles after the select falls.
- R8: A read cycle captures `bus_din` as it stands in the last cycle of the select pulse.
- R9: `cpu_ready` is a one-cycle pulse. For a bus cycle it comes SETUP_CYC+PULSE_CYC+HOLD_CYC+1 cycles after acceptance. For every other access it comes 1 cycle after acceptance.
- R10: `drq_out` follows `drq_in` while mode bit 6 is 0 and is 0 while mode bit 6 is 1.
- R11: After reset the mode, error flag and count are 0, both selects and `cpu_ready` are low, `bus_rw` is 1 and `bus_doe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU access request, held until ready |
| cpu_sel | input | 1 | 0 = data window, 1 = mode (write) / status (read) |
| cpu_we | input | 1 | 1 = write access |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ready | output | 1 | Access complete, one-cycle pulse |
| cpu_rdata | output | 16 | Read data, valid with ready |
| hd_sel | output | 1 | Hard-disk select strobe, active high |
| fd_sel | output | 1 | Floppy select strobe, active high |
| bus_rw | output | 1 | 1 = read, 0 = write on external bus |
| bus_a1 | output | 1 | External address line |
| bus_a2 | output | 1 | Floppy-only address line |
| bus_dout | output | 8 | Byte driven on the external bus |
| bus_doe | output | 1 | Output enable for bus_dout |
| bus_din | input | 8 | Byte read from the external bus |
| drq_in | input | 1 | Data request from the peripheral |
| drq_out | output | 1 | Data request passed to the DMA engine |
| dma_err | input | 1 | Error pulse from the DMA engine |
| sec_dec | input | 1 | Sector-complete pulse, decrements the count |

## Verification
If the mode register were decoded wrongly, it would show at the first data-window access after the mode write. The wrong select would pulse, a select would appear where none should, or a count access would leak onto the bus. A phase counter that is off by one shows up on the same access: the measured setup, pulse and hold widths or the ready latency come out wrong. A stale error flag or a wrong count appears on the next status read. A wrong count-zero condition appears once decrements reach the floor.

// File: rtl/pbcg_pkg.sv
`timescale 1ns/100ps
package pbcg_pkg;

    localparam int MODE_W = 9;

    // Mode fields; bit positions matter because software writes them.
    typedef struct packed {
        logic dir_out;    // bit 8: direction, flipping it clears status
        logic bus_en;     // bit 7: must be 1 for any external cycle
        logic drq_block;  // bit 6: blocks drq towards the DMA engine
        logic rsvd;       // bit 5
        logic cnt_sel;    // bit 4: data window targets the sector count
        logic hd_pick;    // bit 3: 1 = hard-disk strobe, 0 = floppy strobe
        logic fd_a2;      // bit 2: floppy-only address line
        logic a1;         // bit 1: address line
        logic unused0;    // bit 0
    } mode_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD,
        PH_ACK
    } phase_e;

    // One external byte cycle, frozen at acceptance.
    typedef struct packed {
        logic       we;
        logic       hd;
        logic       a1;
        logic       a2;
        logic [7:0] data;
    } cyc_req_t;

    function automatic logic [15:0] pack_status(input logic err,
                                                input logic zero,
                                                input logic drq);
        return {13'd0, drq, zero, err};
    endfunction

endpackage

// File: rtl/pbcg_regs.sv
`timescale 1ns/100ps
module pbcg_regs
    import pbcg_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_wr,
    input  logic               cnt_wr,
    input  logic [15:0]        wdata,
    input  logic               sec_dec,
    input  logic               dma_err,
    input  logic               drq_in,
    output mode_t              mode,
    output logic [COUNT_W-1:0] count,
    output logic [15:0]        status
);

    logic err_q;
    logic dir_flip;

    assign dir_flip = mode_wr && (wdata[MODE_W-1] != mode.dir_out);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode <= mode_t'(wdata[MODE_W-1:0]);
        end
    end

    // A direction flip wins over a simultaneous error pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (dir_flip) begin
            err_q <= 1'b0;
        end else if (dma_err) begin
            err_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wdata[COUNT_W-1:0];
        end else if (sec_dec && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    assign status = pack_status(err_q, count == '0, drq_in);

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        dir_flip |=> !status[0]);                                   // R6
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && sec_dec && !cnt_wr) |=> count == '0);       // R5

endmodule

// File: rtl/pbcg_seq.sv
`timescale 1ns/100ps
module pbcg_seq
    import pbcg_pkg::*;
#(
    parameter int COUNT_W   = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_sel,
    input  logic               cpu_we,
    input  logic [15:0]        cpu_wdata,
    output logic               cpu_ready,
    output logic [15:0]        cpu_rdata,
    input  mode_t              mode,
    input  logic [COUNT_W-1:0] count,
    input  logic [15:0]        status,
    output logic               mode_wr,
    output logic               cnt_wr,
    input  logic [7:0]         bus_din,
    output logic               hd_sel,
    output logic               fd_sel,
    output logic               bus_rw,
    output logic               bus_a1,
    output logic               bus_a2,
    output logic [7:0]         bus_dout,
    output logic               bus_doe
);

    localparam int MAX_PH = (SETUP_CYC > PULSE_CYC)
                          ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                          : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int TW = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

    phase_e         ph;
    logic [TW-1:0]  tick;
    cyc_req_t       req;
    logic           accept;
    logic           win_acc;
    logic           go_bus;
    logic           in_cycle;

    assign accept  = (ph == PH_IDLE) && cpu_valid;
    assign win_acc = accept && !cpu_sel;
    assign go_bus  = win_acc && !mode.cnt_sel && mode.bus_en;
    assign mode_wr = accept && cpu_sel && cpu_we;
    assign cnt_wr  = win_acc && mode.cnt_sel && cpu_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            tick      <= '0;
            req       <= '0;
            cpu_rdata <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (accept) begin
                    if (go_bus) begin
                        ph       <= PH_SETUP;
                        tick     <= TW'(SETUP_CYC - 1);
                        req.we   <= cpu_we;
                        req.hd   <= mode.hd_pick;
                        req.a1   <= mode.a1;
                        req.a2   <= mode.fd_a2 & ~mode.hd_pick;
                        req.data <= cpu_wdata[7:0];
                        cpu_rdata <= '0;
                    end else begin
                        ph <= PH_ACK;
                        if (cpu_we)             cpu_rdata <= '0;
                        else if (cpu_sel)       cpu_rdata <= status;
                        else if (mode.cnt_sel)  cpu_rdata <= 16'(count);
                        else                    cpu_rdata <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tick == '0) begin
                        ph   <= PH_PULSE;
                        tick <= TW'(PULSE_CYC - 1);
                    end else begin
                        tick <= tick - 1'b1;
                    end
                end
                PH_PULSE: begin
                    if (tick == '0) begin
                        ph   <= PH_HOLD;
                        tick <= TW'(HOLD_CYC - 1);
                        if (!req.we) cpu_rdata <= {8'd0, bus_din};
                    end else begin
                        tick <= tick - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (tick == '0) ph <= PH_ACK;
                    else            tick <= tick - 1'b1;
                end
                PH_ACK: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign in_cycle  = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
    assign hd_sel    = (ph == PH_PULSE) &&  req.hd;
    assign fd_sel    = (ph == PH_PULSE) && !req.hd;
    assign bus_rw    = in_cycle ? ~req.we : 1'b1;
    assign bus_a1    = in_cycle & req.a1;
    assign bus_a2    = in_cycle & req.a2;
    assign bus_doe   = in_cycle & req.we;
    assign bus_dout  = req.data;
    assign cpu_ready = (ph == PH_ACK);

    AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(hd_sel && fd_sel));                                        // R2
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);                                   // R9
    AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((hd_sel || fd_sel) && $past(hd_sel || fd_sel)) |->
        ($stable(bus_dout) && $stable(bus_a1) && $stable(bus_rw)));  // R7

endmodule

// File: rtl/pbus_cycle_gen.sv
`timescale 1ns/100ps
module pbus_cycle_gen
    import pbcg_pkg::*;
#(
    parameter int COUNT_W   = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_valid,
    input  logic        cpu_sel,
    input  logic        cpu_we,
    input  logic [15:0] cpu_wdata,
    output logic        cpu_ready,
    output logic [15:0] cpu_rdata,
    output logic        hd_sel,
    output logic        fd_sel,
    output logic        bus_rw,
    output logic        bus_a1,
    output logic        bus_a2,
    output logic [7:0]  bus_dout,
    output logic        bus_doe,
    input  logic [7:0]  bus_din,
    input  logic        drq_in,
    output logic        drq_out,
    input  logic        dma_err,
    input  logic        sec_dec
);

    mode_t              mode;
    logic [COUNT_W-1:0] count;
    logic [15:0]        status;
    logic               mode_wr;
    logic               cnt_wr;

    pbcg_regs #(.COUNT_W(COUNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .mode_wr (mode_wr),
        .cnt_wr  (cnt_wr),
        .wdata   (cpu_wdata),
        .sec_dec (sec_dec),
        .dma_err (dma_err),
        .drq_in  (drq_in),
        .mode    (mode),
        .count   (count),
        .status  (status)
    );

    pbcg_seq #(
        .COUNT_W   (COUNT_W),
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_sel   (cpu_sel),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .mode      (mode),
        .count     (count),
        .status    (status),
        .mode_wr   (mode_wr),
        .cnt_wr    (cnt_wr),
        .bus_din   (bus_din),
        .hd_sel    (hd_sel),
        .fd_sel    (fd_sel),
        .bus_rw    (bus_rw),
        .bus_a1    (bus_a1),
        .bus_a2    (bus_a2),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe)
    );

    assign drq_out = drq_in & ~mode.drq_block;

    AST_DRQ_BLOCK: assert property (@(posedge clk) disable iff (rst)
        mode.drq_block |-> !drq_out);                                // R10
    AST_NO_CYC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (hd_sel || fd_sel) |-> (mode.bus_en && !mode.cnt_sel));      // R4

endmodule

// File: tb/pbus_cycle_gen_bench.sv
`timescale 1ns/100ps
module pbus_cycle_gen_bench;

    localparam int S = 2, P = 4, H = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0, cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        hd_sel, fd_sel, bus_rw, bus_a1, bus_a2, bus_doe;
    logic [7:0]  bus_dout, bus_din;
    logic        drq_in = 1'b0, drq_out, dma_err = 1'b0, sec_dec = 1'b0;

    int total = 0, bad = 0;
    bit finished = 0;

    // Peripheral model: one byte while selected, another otherwise.
    assign bus_din = (hd_sel || fd_sel) ? 8'h5A : 8'hC3;

    always #2.5 clk = ~clk;

    pbus_cycle_gen #(.COUNT_W(8), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H))
    u_pbus_cycle_gen (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_sel(cpu_sel),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .hd_sel(hd_sel), .fd_sel(fd_sel),
        .bus_rw(bus_rw), .bus_a1(bus_a1), .bus_a2(bus_a2),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .drq_in(drq_in), .drq_out(drq_out), .dma_err(dma_err),
        .sec_dec(sec_dec)
    );

    // Observations of the last access.
    int         lat, n_pre, n_pulse, n_post;
    bit         saw_hd, saw_fd, p_a1, p_a2, p_rw, p_unstable;
    logic [7:0] p_dout;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic sel, input logic we, input logic [15:0] wd,
                          output logic [15:0] rd);
        bit seen;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_sel = sel; cpu_we = we; cpu_wdata = wd;
        lat = 0; n_pre = 0; n_pulse = 0; n_post = 0; seen = 0;
        saw_hd = 0; saw_fd = 0; p_unstable = 0;
        p_a1 = 0; p_a2 = 0; p_rw = 1; p_dout = '0;
        do begin
            @(negedge clk);
            lat++;
            if (hd_sel) saw_hd = 1;
            if (fd_sel) saw_fd = 1;
            if (hd_sel || fd_sel) begin
                if (n_pulse == 0) begin
                    p_a1 = bus_a1; p_a2 = bus_a2; p_rw = bus_rw; p_dout = bus_dout;
                end else if (bus_a1 != p_a1 || bus_rw != p_rw || bus_dout != p_dout)
                    p_unstable = 1;
                n_pulse++; seen = 1;
            end else if (bus_doe && !seen) n_pre++;
            else if (bus_doe && seen) n_post++;
        end while (!cpu_ready && lat < 100);
        rd = cpu_rdata;
        cpu_valid = 1'b0;
    endtask

    task automatic pulse_in(input int which);
        @(negedge clk);
        if (which == 0) dma_err = 1'b1; else sec_dec = 1'b1;
        @(negedge clk);
        dma_err = 1'b0; sec_dec = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] rd;
        check(!hd_sel && !fd_sel && !cpu_ready && bus_rw && !bus_doe,
              "R11 idle outputs", {hd_sel, fd_sel, cpu_ready, bus_rw, bus_doe}, 5'b00010);
        access(1, 0, 0, rd);
        check(rd == 16'h0002, "R11 status after reset", rd, 16'h0002);
    endtask

    task automatic t_hd_write;
        logic [15:0] rd;
        access(1, 1, 16'h008A, rd);           // bus_en, hd, a1
        access(0, 1, 16'h1234, rd);
        check(saw_hd && !saw_fd, "R2 hd strobe", {saw_hd, saw_fd}, 2'b10);
        check(p_dout == 8'h34 && p_rw == 1'b0, "R1 write byte", {p_rw, p_dout}, 9'h034);
        check(p_a1 == 1'b1 && p_a2 == 1'b0, "R3 hd address", {p_a1, p_a2}, 2'b10);
        check(n_pre == S && n_pulse == P && n_post == H, "R7 phase widths",
              n_pre * 100 + n_pulse * 10 + n_post, S * 100 + P * 10 + H);
        check(!p_unstable, "R7 stable in pulse", p_unstable, 0);
        check(lat == S + P + H + 1, "R9 bus latency", lat, S + P + H + 1);
    endtask

    task automatic t_fd_read;
        logic [15:0] rd;
        access(1, 1, 16'h0084, rd);           // bus_en, floppy, a2
        access(0, 0, 16'h0000, rd);
        check(saw_fd && !saw_hd, "R2 fd strobe", {saw_hd, saw_fd}, 2'b01);
        check(p_a2 == 1'b1 && p_a1 == 1'b0 && p_rw == 1'b1, "R3 fd address",
              {p_a1, p_a2, p_rw}, 3'b011);
        check(rd == 16'h005A, "R8 read sample", rd, 16'h005A);
        check(rd[15:8] == 0 && n_pulse == P, "R1 read cycle", {rd[15:8], n_pulse}, P);
    endtask

    task automatic t_blocked;
        logic [15:0] rd;
        access(1, 1, 16'h0008, rd);           // bus_en clear
        access(0, 1, 16'h00FF, rd);
        check(!saw_hd && !saw_fd && n_pre == 0, "R4 no cycle", {saw_hd, saw_fd}, 0);
        check(lat == 1, "R9 short latency", lat, 1);
        access(0, 0, 0, rd);
        check(rd == 0 && !saw_hd && !saw_fd, "R4 read zero", rd, 0);
    endtask

    task automatic t_count;
        logic [15:0] rd;
        access(1, 1, 16'h0090, rd);           // bus_en, count select
        access(0, 1, 16'h0003, rd);
        check(!saw_hd && !saw_fd, "R5 no bus on count write", {saw_hd, saw_fd}, 0);
        access(0, 0, 0, rd);
        check(rd == 16'h0003, "R5 count read", rd, 3);
        access(1, 0, 0, rd);
        check(rd == 16'h0000, "R6 nonzero count status", rd, 0);
        for (int i = 0; i < 3; i++) pulse_in(1);
        access(0, 0, 0, rd);
        check(rd == 0, "R5 count decremented", rd, 0);
        access(1, 0, 0, rd);
        check(rd == 16'h0002, "R6 zero flag", rd, 2);
        pulse_in(1);
        access(0, 0, 0, rd);
        check(rd == 0, "R5 floor at zero", rd, 0);
    endtask

    task automatic t_error;
        logic [15:0] rd;
        pulse_in(0);
        access(1, 0, 0, rd);
        check(rd[0] == 1'b1, "R6 error set", rd, 16'h0003);
        access(1, 1, 16'h0090, rd);           // same dir bit
        access(1, 0, 0, rd);
        check(rd[0] == 1'b1, "R6 error kept", rd, 16'h0003);
        access(1, 1, 16'h0190, rd);           // 0 -> 1
        access(1, 0, 0, rd);
        check(rd[0] == 1'b0, "R6 clear on rise", rd, 16'h0002);
        pulse_in(0);
        access(1, 1, 16'h0090, rd);           // 1 -> 0
        access(1, 0, 0, rd);
        check(rd == 16'h0002, "R6 clear on fall", rd, 16'h0002);
    endtask

    task automatic t_drq;
        logic [15:0] rd;
        access(1, 1, 16'h0000, rd);
        drq_in = 1'b1;
        @(negedge clk);
        check(drq_out == 1'b1, "R10 drq passes", drq_out, 1);
        access(1, 0, 0, rd);
        check(rd == 16'h0006, "R6 drq status", rd, 16'h0006);
        access(1, 1, 16'h0040, rd);
        @(negedge clk);
        check(drq_out == 1'b0, "R10 drq blocked", drq_out, 0);
        access(1, 0, 0, rd);
        check(rd[2] == 1'b1, "R6 drq live when blocked", rd, 16'h0006);
        drq_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hd_write();
        t_fd_read();
        t_blocked();
        t_count();
        t_error();
        t_drq();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule